// File: doc/BRIEF.md
# Serial Converter Command Receiver

This block is the digital front end of a 12-bit voltage-output converter. A host writes to it over a three-wire serial link made up of an active-low select, a serial clock and a data line. Every command is one 16-bit word. The block receives the word, decodes its 3-bit control field and updates two registers. The first is a holding register that software can preload. The second is the converter register, and its value drives the analog stage. A shutdown state forces the converter code to zero while both registers keep their contents. That state is left either by a recall command, which brings back the code held before shutdown, or by any command that writes new converter data.

The serial pins are asynchronous to the block. They are brought into a faster system clock through two-stage synchronizers, and all edges are detected on the synchronized copies. A word is applied only when the select line rises, and only if exactly sixteen serial clock edges were seen while it was low.

Top module: `serdac_cmd_if`

## Requirements
- R1: A frame is 16 bits, sent MSB first. Bits 15..13 hold the control code, bits 12..1 hold the data D11..D0, and bit 0 is a sub-bit that is received and ignored.
- R2: Data is sampled only on a rising serial clock edge while `cs_n_i` is low. Clock and data activity while `cs_n_i` is high leaves the outputs unchanged.
- R3: A received word takes effect only after `cs_n_i` rises. After the 16th clock edge, with select still low, the outputs are unchanged.
- R4: A frame that ends with fewer or more than 16 clock edges is discarded and changes no register.
- R5: A frame sent as two 8-bit bursts with `cs_n_i` held low between them is accepted like a single burst.
- R6: Code 001 loads the holding register only. The converter code and the shutdown state are unchanged.
- R7: Code 010 loads both registers with the data and clears shutdown.
- R8: Code 011 copies the holding register into the converter register and clears shutdown. Its data bits are ignored.
- R9: Code 100 enters shutdown. `shdn_o` becomes 1, `dac_code_o` reads 0, both registers are kept, and the data bits are ignored.
- R10: Code 101 leaves shutdown and `dac_code_o` again shows the converter register held before shutdown. Its data bits are ignored.
- R11: Codes 000, 110 and 111 change nothing.
- R12: After reset both registers are zero, `shdn_o` is 0 and `dac_code_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Serial select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| din_i | input | 1 | Serial data in, asynchronous |
| dac_code_o | output | 12 | Code presented to the converter (zero in shutdown) |
| shdn_o | output | 1 | Shutdown state flag |

## Verification
The hardest case to reach is a command arriving while shutdown is active with different values held in the holding and converter registers. Only in that case do recall, transfer and input-only loads give visibly different results. The bench therefore sweeps every control code against both shutdown states, after setup frames that load distinct values into the two registers. It also checks the ignored and deferred cases at the pins: it holds select low after sixteen edges, toggles the clock with select high, and sends 15- and 17-edge frames.

// File: rtl/dac_cmd_pkg.sv
// Package: shared widths and control-code encoding for the serial
// converter command receiver.
package dac_cmd_pkg;

    localparam int CTRL_W = 3;
    localparam int DATA_W = 12;
    localparam int SUB_W  = 1;
    localparam int WORD_W = CTRL_W + DATA_W + SUB_W;

    typedef enum logic [CTRL_W-1:0] {
        OP_NOP      = 3'b000,
        OP_LOAD_IN  = 3'b001,
        OP_LOAD_ALL = 3'b010,
        OP_XFER     = 3'b011,
        OP_SLEEP    = 3'b100,
        OP_WAKE     = 3'b101,
        OP_RSV6     = 3'b110,
        OP_RSV7     = 3'b111
    } op_e;

endpackage

// File: rtl/pin_sync.sv
// Module: pin_sync
// Purpose: two-stage synchronizer for a bundle of asynchronous pins.
// Assumes: each bit is independent; reset value chosen per bit so that
// idle levels do not produce spurious edges after reset.
module pin_sync #(
    parameter int              W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            logic meta_q;
            logic stab_q;

            // Two flops per pin to settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= RST_VAL[g];
                    stab_q <= RST_VAL[g];
                end else begin
                    meta_q <= async_i[g];
                    stab_q <= meta_q;
                end
            end

            assign sync_o[g] = stab_q;
        end
    endgenerate

endmodule

// File: rtl/frame_rx.sv
// Module: frame_rx
// Purpose: collects one serial word from synchronized pins and releases it
// with a one-cycle strobe on the select rising edge when exactly WORD_W
// clock edges were received.
// Assumes: inputs already synchronized; system clock >= 4x serial clock.
module frame_rx #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              din_s,
    output logic              frame_valid_o,
    output logic [WORD_W-1:0] frame_word_o
);

    localparam int CNT_MAX = WORD_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic              cs_n_d;
    logic              sclk_d;
    logic              cs_rise;
    logic              sclk_rise;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] shift_q;
    logic              valid_q;

    // Edge detection on the synchronized select and clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_d <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            cs_n_d <= cs_n_s;
            sclk_d <= sclk_s;
        end
    end

    assign cs_rise   = cs_n_s & ~cs_n_d;
    assign sclk_rise = sclk_s & ~sclk_d;

    // Bit counter: cleared while deselected, saturates past a full word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (cs_n_s) begin
            bit_cnt <= '0;
        end else if (sclk_rise && (bit_cnt != CNT_W'(CNT_MAX))) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Shift register: MSB first, shifts only while selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (!cs_n_s && sclk_rise) begin
            shift_q <= {shift_q[WORD_W-2:0], din_s};
        end
    end

    // Release strobe on select rise with an exact bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= cs_rise && (bit_cnt == CNT_W'(WORD_W));
        end
    end

    assign frame_valid_o = valid_q;
    assign frame_word_o  = shift_q;

    // R2: nothing shifts in while deselected.
    a_r2_idle_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && cs_n_d) |=> $stable(shift_q));

    // R3: a release strobe lasts one cycle and only follows a deselect.
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (cs_n_s && !$past(valid_q)));

    // R4: the counter never runs past its saturation point.
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(CNT_MAX));

endmodule

// File: rtl/dac_regs.sv
// Module: dac_regs
// Purpose: decodes a received word and updates the holding register, the
// converter register and the shutdown state.
// Assumes: word_i is stable whenever valid_i is high.
module dac_regs
    import dac_cmd_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [DW-1:0]     dac_code_o,
    output logic              shdn_o
);

    op_e           op;
    logic [DW-1:0] data;
    logic [DW-1:0] hold_q;
    logic [DW-1:0] conv_q;
    logic          shdn_q;

    assign op   = op_e'(word_i[WORD_W-1 -: CTRL_W]);
    assign data = word_i[SUB_W +: DW];

    // Command execution on each released word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            conv_q <= '0;
            shdn_q <= 1'b0;
        end else if (valid_i) begin
            case (op)
                OP_LOAD_IN: begin
                    hold_q <= data;
                end
                OP_LOAD_ALL: begin
                    hold_q <= data;
                    conv_q <= data;
                    shdn_q <= 1'b0;
                end
                OP_XFER: begin
                    conv_q <= hold_q;
                    shdn_q <= 1'b0;
                end
                OP_SLEEP: begin
                    shdn_q <= 1'b1;
                end
                OP_WAKE: begin
                    shdn_q <= 1'b0;
                end
                default: begin
                end
            endcase
        end
    end

    // Converter sees zero during shutdown; stored code is preserved.
    assign dac_code_o = shdn_q ? '0 : conv_q;
    assign shdn_o     = shdn_q;

    // R11: without a released word no state moves.
    a_r11_no_frame_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(hold_q) && $stable(conv_q) && $stable(shdn_q)));

    // R6: input-only load leaves the converter side untouched.
    a_r6_input_only: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op == OP_LOAD_IN) |=> ($stable(conv_q) && $stable(shdn_q)));

    // R9: shutdown is only entered by the sleep command.
    a_r9_sleep_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shdn_q) |-> $past(valid_i && op == OP_SLEEP));

    // R10: recall restores the stored code untouched.
    a_r10_wake_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op == OP_WAKE) |=> (!shdn_q && $stable(conv_q) && $stable(hold_q)));

endmodule

// File: rtl/serdac_cmd_if.sv
// Module: serdac_cmd_if (top)
// Purpose: three-wire serial command receiver for a 12-bit converter with
// double-buffered registers and a recallable shutdown state.
// Assumes: clk is at least four times the fastest serial clock.
module serdac_cmd_if
    import dac_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              din_i,
    output logic [DATA_W-1:0] dac_code_o,
    output logic              shdn_o
);

    localparam int PINS = 3;

    logic [PINS-1:0]   pins_s;
    logic              fv;
    logic [WORD_W-1:0] fw;

    pin_sync #(
        .W       (PINS),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n_i, sclk_i, din_i}),
        .sync_o  (pins_s)
    );

    frame_rx #(
        .WORD_W (WORD_W)
    ) u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_n_s        (pins_s[2]),
        .sclk_s        (pins_s[1]),
        .din_s         (pins_s[0]),
        .frame_valid_o (fv),
        .frame_word_o  (fw)
    );

    dac_regs #(
        .DW (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (fv),
        .word_i     (fw),
        .dac_code_o (dac_code_o),
        .shdn_o     (shdn_o)
    );

    // R12: the first cycle after reset shows the cleared state.
    a_r12_reset_state: assert property (@(posedge clk)
        $rose(rst_n) |-> (dac_code_o == '0 && !shdn_o));

endmodule

// File: tb/tb_serdac_cmd_if.sv
module tb_serdac_cmd_if;

    localparam int HP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic [11:0] code;
    logic        sd;

    int checks = 0;
    int fails  = 0;
    logic [11:0] ein = '0, edac = '0;
    logic        esd = 1'b0;

    always #10 clk = ~clk;

    serdac_cmd_if dut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk),
        .din_i(din), .dac_code_o(code), .shdn_o(sd)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [12:0] got, input logic [12:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got sd=%0d code=%0d, expected sd=%0d code=%0d",
                     tag, got[12], got[11:0], exp[12], exp[11:0]);
        end
    endtask

    function automatic logic [12:0] expv();
        return {esd, esd ? 12'd0 : edac};
    endfunction

    task automatic clk_bit(input logic b);
        din = b; wait_n(HP);
        sclk = 1'b1; wait_n(HP);
        sclk = 1'b0;
    endtask

    // Shift nbits of w (MSB of a 16-bit word first, extra bits are zero).
    task automatic shift_bits(input logic [15:0] w, input int nbits, input bit split);
        for (int i = 0; i < nbits; i++) begin
            clk_bit(i < 16 ? w[15-i] : 1'b0);
            if (split && i == 7) wait_n(20);
        end
    endtask

    task automatic send(input logic [15:0] w, input int nbits, input bit split);
        cs_n = 1'b0; wait_n(HP);
        shift_bits(w, nbits, split);
        wait_n(HP);
        cs_n = 1'b1;
        wait_n(10);
    endtask

    function automatic logic [15:0] mk(input logic [2:0] op, input logic [11:0] d, input logic s);
        return {op, d, s};
    endfunction

    task automatic model(input logic [2:0] op, input logic [11:0] d);
        case (op)
            3'd1: ein = d;
            3'd2: begin ein = d; edac = d; esd = 1'b0; end
            3'd3: begin edac = ein; esd = 1'b0; end
            3'd4: esd = 1'b1;
            3'd5: esd = 1'b0;
            default: ;
        endcase
    endtask

    task automatic cmd(input string tag, input logic [2:0] op, input logic [11:0] d);
        send(mk(op, d, 1'b0), 16, 1'b0);
        model(op, d);
        check(tag, {sd, code}, expv());
    endtask

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd1: return "R6 load input";
            3'd2: return "R7 load both";
            3'd3: return "R8 transfer";
            3'd4: return "R9 sleep";
            3'd5: return "R10 wake";
            default: return "R11 no-op";
        endcase
    endfunction

    initial begin
        wait_n(5);
        // R12: reset state
        check("R12 reset", {sd, code}, 13'd0);
        rst_n = 1'b1;
        wait_n(5);
        check("R12 after reset", {sd, code}, 13'd0);

        // R1 / R7: data sweep through direct load, bit order MSB first
        for (int k = 0; k < 64; k++) begin
            logic [11:0] d;
            d = 12'((k * 1237 + 5) % 4096);
            cmd("R1 R7 data sweep", 3'd2, d);
        end
        cmd("R1 R7 all ones", 3'd2, 12'hFFF);
        cmd("R1 R7 single MSB", 3'd2, 12'h800);

        // R1: sub-bit set has no effect
        send(mk(3'd2, 12'h0A5, 1'b1), 16, 1'b0);
        model(3'd2, 12'h0A5);
        check("R1 sub-bit ignored", {sd, code}, expv());

        // R3: after 16 edges but before select rises, nothing changes
        cs_n = 1'b0; wait_n(HP);
        shift_bits(mk(3'd2, 12'h3C3, 1'b0), 16, 1'b0);
        wait_n(20);
        check("R3 deferred until select rise", {sd, code}, expv());
        cs_n = 1'b1; wait_n(10);
        model(3'd2, 12'h3C3);
        check("R3 applied on select rise", {sd, code}, expv());

        // R4: short and long frames are discarded
        send(mk(3'd2, 12'h111, 1'b0), 15, 1'b0);
        check("R4 15-edge frame dropped", {sd, code}, expv());
        send(mk(3'd2, 12'h222, 1'b0), 17, 1'b0);
        check("R4 17-edge frame dropped", {sd, code}, expv());

        // R2: clock and data toggling while deselected are ignored
        for (int i = 0; i < 20; i++) clk_bit(i[0]);
        wait_n(10);
        check("R2 idle activity ignored", {sd, code}, expv());
        cmd("R2 next frame clean", 3'd2, 12'h5A5);

        // R5: two 8-bit bursts
        send(mk(3'd2, 12'hC0F, 1'b0), 16, 1'b1);
        model(3'd2, 12'hC0F);
        check("R5 split frame", {sd, code}, expv());

        // Sweep: every code x shutdown state x data with distinct registers
        for (int op = 0; op < 8; op++) begin
            for (int s = 0; s < 2; s++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [11:0] base, hold, d;
                    base = 12'(100 + 700 * k);
                    hold = 12'(3000 - 500 * k);
                    d    = 12'(17 + 999 * k + 31 * op);
                    cmd("R7 setup", 3'd2, base);
                    cmd("R6 setup", 3'd1, hold);
                    if (s == 1) cmd("R9 setup", 3'd4, 12'hABC);
                    cmd(op_tag(3'(op)), 3'(op), d);
                    // expose the holding register through a transfer
                    cmd("R6 R8 hold readback", 3'd3, 12'h000);
                end
            end
        end

        // R10: wake restores the pre-shutdown code
        cmd("R7 set", 3'd2, 12'h6D2);
        cmd("R9 sleep", 3'd4, 12'hFFF);
        cmd("R6 load in while asleep", 3'd1, 12'h123);
        cmd("R10 recall", 3'd5, 12'h777);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule